// File: doc/BRIEF.md
# Sampling Tap Drift Corrector

This block keeps a high-speed card interface sampling point centred while data is moving. A phase detector elsewhere compares data and command samples against neighbouring taps and raises request flags. Each time the host strobes `check_req`, this unit looks at those flags and the command-line compare bits. It then either moves the sampling tap one step up or down, asks for a full retune, or does nothing. It also returns a one-cycle pulse that tells the detector to clear its sticky flags.

The unit runs only in the fast timings (SDR104, HS200 and HS400). It stands aside while a tuning sweep is running. With automatic correction enabled, the detector moves the tap by itself and this unit only turns a detected error into a retune request. In manual mode it does the tap arithmetic itself. That arithmetic wraps modulo the tap count. When the 4-tap option is set, the value it hands back for programming is half the logical tap.

Top module: `tap_drift_corrector`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `flag_clr`, `retune_req` and `tap_wr` are 0, and `tap_new` and `tap_prog` are 0.
- R2: `timing_mode` encodes 0 = slower timing, 1 = SDR104, 2 = HS200, 3 = HS400. A strobe in mode 0, or in mode 3 with `four_tap_en` high, produces no pulse on any output.
- R3: A strobe while `tune_busy` is high produces no pulse on any output.
- R4: With `auto_en` high, only the error flag (`req_flags` bit 2) counts. If it is set, the unit pulses `flag_clr` and `retune_req`. Otherwise it does nothing, and in neither case does it write the tap.
- R5: In manual mode (`auto_en` low), a strobe with `req_flags` all zero does nothing, whatever `cmd_sense` holds.
- R6: In manual mode outside HS400, any nonzero `req_flags` pulses `flag_clr`. The priority is bit 2 (error, retune) over bit 1 (tap up) over bit 0 (tap down).
- R7: In manual HS400 with nonzero `req_flags`, `flag_clr` pulses and only `cmd_sense` decides the action. Bit 0 (fed from compare bit 8) means down and bit 1 (fed from compare bit 24) means up. Neither bit set means no move, exactly one set moves the tap, and both set requests a retune.
- R8: Tap moves wrap modulo `TAP_NUM`: up from `TAP_NUM`-1 gives 0, and down from 0 gives `TAP_NUM`-1. `tap_cur` must be below `TAP_NUM`.
- R9: On a tap write, `tap_prog` equals `tap_new` divided by 2 (rounded down) when `four_tap_en` was high at the strobe, and equals `tap_new` otherwise.
- R10: Every pulse appears exactly one cycle after the strobe and lasts one cycle. `tap_new` and `tap_prog` change only together with `tap_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| check_req | input | 1 | Strobe: evaluate the flags this cycle |
| timing_mode | input | 2 | Bus timing code (see R2) |
| four_tap_en | input | 1 | 4-tap option active |
| auto_en | input | 1 | Detector corrects the tap by itself |
| tune_busy | input | 1 | Tuning or retuning in progress |
| req_flags | input | 3 | bit0 down, bit1 up, bit2 error |
| cmd_sense | input | 2 | Command compare: bit0 down, bit1 up |
| tap_cur | input | TAP_W | Currently selected logical tap |
| flag_clr | output | 1 | Pulse: clear the detector flags |
| retune_req | output | 1 | Pulse: full retune needed |
| tap_wr | output | 1 | Pulse: program a new tap |
| tap_new | output | TAP_W | New logical tap |
| tap_prog | output | TAP_W | Value to program into the tap selector |

## Verification
A wrong priority or mode decode shows at the ports on the cycle after the strobe. It appears as a missing or extra `flag_clr`, a retune where a move belongs, or the reverse. A wrap fault shows as a wrong `tap_new` only at taps 0 and `TAP_NUM`-1, so the sweep visits every tap in every direction. A halving fault shows in `tap_prog` on the same cycle. A stuck pulse or a tap that changes without a write shows one cycle later, when the sample is taken with the strobe low.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    typedef enum logic [1:0] {
        TM_SLOW   = 2'd0,
        TM_SDR104 = 2'd1,
        TM_HS200  = 2'd2,
        TM_HS400  = 2'd3
    } timing_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_UP     = 2'd1,
        ACT_DOWN   = 2'd2,
        ACT_RETUNE = 2'd3
    } act_e;

    localparam int REQ_W        = 3;
    localparam int REQ_DOWN_BIT = 0;
    localparam int REQ_UP_BIT   = 1;
    localparam int REQ_ERR_BIT  = 2;
    localparam int CMD_DOWN_BIT = 0;
    localparam int CMD_UP_BIT   = 1;
endpackage

// File: rtl/tdc_gate.sv
module tdc_gate
    import tdc_pkg::*;
(
    input  logic       check_i,
    input  logic [1:0] timing_i,
    input  logic       four_tap_i,
    input  logic       busy_i,
    output logic       active_o,
    output logic       hs400_o
);
    logic mode_ok;

    always_comb begin
        hs400_o = (timing_i == TM_HS400);
        unique case (timing_i)
            TM_SDR104, TM_HS200: mode_ok = 1'b1;
            TM_HS400:            mode_ok = !four_tap_i;
            default:             mode_ok = 1'b0;
        endcase
        active_o = check_i && mode_ok && !busy_i;
    end
endmodule

// File: rtl/tdc_decide.sv
module tdc_decide
    import tdc_pkg::*;
(
    input  logic             active_i,
    input  logic             auto_i,
    input  logic             hs400_i,
    input  logic [REQ_W-1:0] req_i,
    input  logic [1:0]       cmd_i,
    output logic             clr_o,
    output act_e             act_o
);
    always_comb begin
        clr_o = 1'b0;
        act_o = ACT_NONE;
        if (active_i) begin
            if (auto_i) begin
                if (req_i[REQ_ERR_BIT]) begin
                    clr_o = 1'b1;
                    act_o = ACT_RETUNE;
                end
            end else if (req_i != '0) begin
                clr_o = 1'b1;
                if (hs400_i) begin
                    unique case ({cmd_i[CMD_UP_BIT], cmd_i[CMD_DOWN_BIT]})
                        2'b10:   act_o = ACT_UP;
                        2'b01:   act_o = ACT_DOWN;
                        2'b11:   act_o = ACT_RETUNE;
                        default: act_o = ACT_NONE;
                    endcase
                end else if (req_i[REQ_ERR_BIT]) begin
                    act_o = ACT_RETUNE;
                end else if (req_i[REQ_UP_BIT]) begin
                    act_o = ACT_UP;
                end else begin
                    act_o = ACT_DOWN;
                end
            end
        end
    end
endmodule

// File: rtl/tdc_tap_math.sv
module tdc_tap_math
    import tdc_pkg::*;
#(
    parameter int TAP_NUM = 8,
    parameter int TAP_W   = 3
) (
    input  logic [TAP_W-1:0] tap_i,
    input  act_e             act_i,
    input  logic             four_tap_i,
    output logic [TAP_W-1:0] tap_o,
    output logic [TAP_W-1:0] prog_o
);
    localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(TAP_NUM - 1);
    localparam bit POW2 = ((1 << TAP_W) == TAP_NUM);

    logic [TAP_W-1:0] up_v;
    logic [TAP_W-1:0] dn_v;

    generate
        if (POW2) begin : g_pow2
            always_comb begin
                up_v = tap_i + TAP_W'(1);
                dn_v = tap_i - TAP_W'(1);
            end
        end else begin : g_cmp
            always_comb begin
                up_v = (tap_i >= TAP_LAST) ? '0 : tap_i + TAP_W'(1);
                dn_v = (tap_i == '0) ? TAP_LAST : tap_i - TAP_W'(1);
            end
        end
    endgenerate

    always_comb begin
        unique case (act_i)
            ACT_UP:   tap_o = up_v;
            ACT_DOWN: tap_o = dn_v;
            default:  tap_o = tap_i;
        endcase
        prog_o = four_tap_i ? (tap_o >> 1) : tap_o;
    end
endmodule

// File: rtl/tap_drift_corrector.sv
module tap_drift_corrector
    import tdc_pkg::*;
#(
    parameter int TAP_NUM = 8,
    localparam int TAP_W  = (TAP_NUM > 2) ? $clog2(TAP_NUM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_req,
    input  logic [1:0]       timing_mode,
    input  logic             four_tap_en,
    input  logic             auto_en,
    input  logic             tune_busy,
    input  logic [REQ_W-1:0] req_flags,
    input  logic [1:0]       cmd_sense,
    input  logic [TAP_W-1:0] tap_cur,
    output logic             flag_clr,
    output logic             retune_req,
    output logic             tap_wr,
    output logic [TAP_W-1:0] tap_new,
    output logic [TAP_W-1:0] tap_prog
);
    typedef struct packed {
        logic             clr;
        logic             retune;
        logic             wr;
        logic [TAP_W-1:0] tap;
        logic [TAP_W-1:0] prog;
    } state_t;

    state_t st_d, st_q;

    logic             active_w;
    logic             hs400_w;
    logic             clr_w;
    act_e             act_w;
    logic [TAP_W-1:0] tap_w;
    logic [TAP_W-1:0] prog_w;

    tdc_gate i_gate (
        .check_i    (check_req),
        .timing_i   (timing_mode),
        .four_tap_i (four_tap_en),
        .busy_i     (tune_busy),
        .active_o   (active_w),
        .hs400_o    (hs400_w)
    );

    tdc_decide i_decide (
        .active_i (active_w),
        .auto_i   (auto_en),
        .hs400_i  (hs400_w),
        .req_i    (req_flags),
        .cmd_i    (cmd_sense),
        .clr_o    (clr_w),
        .act_o    (act_w)
    );

    tdc_tap_math #(
        .TAP_NUM (TAP_NUM),
        .TAP_W   (TAP_W)
    ) i_math (
        .tap_i      (tap_cur),
        .act_i      (act_w),
        .four_tap_i (four_tap_en),
        .tap_o      (tap_w),
        .prog_o     (prog_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.clr    = clr_w;
        st_d.retune = (act_w == ACT_RETUNE);
        st_d.wr     = (act_w == ACT_UP) || (act_w == ACT_DOWN);
        if (st_d.wr) begin
            st_d.tap  = tap_w;
            st_d.prog = prog_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_clr   = st_q.clr;
    assign retune_req = st_q.retune;
    assign tap_wr     = st_q.wr;
    assign tap_new    = st_q.tap;
    assign tap_prog   = st_q.prog;
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
    parameter int TAP_NUM = 8,
    parameter int TAP_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             check_req,
    input logic [1:0]       timing_mode,
    input logic             four_tap_en,
    input logic             auto_en,
    input logic             tune_busy,
    input logic [2:0]       req_flags,
    input logic [1:0]       cmd_sense,
    input logic             flag_clr,
    input logic             retune_req,
    input logic             tap_wr,
    input logic [TAP_W-1:0] tap_new,
    input logic [TAP_W-1:0] tap_prog
);
    AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        check_req && (timing_mode == 2'd0 || (timing_mode == 2'd3 && four_tap_en))
        |=> !flag_clr && !retune_req && !tap_wr); // R2

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        check_req && tune_busy |=> !flag_clr && !retune_req && !tap_wr); // R3

    AST_AUTO_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        check_req && auto_en |=> !tap_wr); // R4

    AST_ZERO_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        check_req && !auto_en && req_flags == 3'd0
        |=> !flag_clr && !retune_req && !tap_wr); // R5

    AST_MOVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tap_wr |-> flag_clr && !retune_req); // R6

    AST_CMD_BOTH_RETUNE: assert property (@(posedge clk) disable iff (!rst_n)
        check_req && !auto_en && !tune_busy && timing_mode == 2'd3 && !four_tap_en
        && req_flags != 3'd0 && cmd_sense == 2'b11 |=> retune_req && !tap_wr); // R7

    AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tap_wr |-> int'(tap_new) < TAP_NUM); // R8

    AST_PROG_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        tap_wr |-> tap_prog == ($past(four_tap_en) ? (tap_new >> 1) : tap_new)); // R9

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr || retune_req || tap_wr) |-> $past(check_req)); // R10

    AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tap_wr |-> $stable(tap_new) && $stable(tap_prog)); // R10
endmodule

bind tap_drift_corrector tdc_checker #(
    .TAP_NUM (TAP_NUM),
    .TAP_W   (TAP_W)
) i_tdc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .check_req   (check_req),
    .timing_mode (timing_mode),
    .four_tap_en (four_tap_en),
    .auto_en     (auto_en),
    .tune_busy   (tune_busy),
    .req_flags   (req_flags),
    .cmd_sense   (cmd_sense),
    .flag_clr    (flag_clr),
    .retune_req  (retune_req),
    .tap_wr      (tap_wr),
    .tap_new     (tap_new),
    .tap_prog    (tap_prog)
);

// File: tb/test_tap_drift_corrector.sv
module test_tap_drift_corrector;
    localparam int N = 8;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         check_req = 1'b0;
    logic [1:0]   timing_mode = '0;
    logic         four_tap_en = 1'b0;
    logic         auto_en = 1'b0;
    logic         tune_busy = 1'b0;
    logic [2:0]   req_flags = '0;
    logic [1:0]   cmd_sense = '0;
    logic [W-1:0] tap_cur = '0;
    logic         flag_clr;
    logic         retune_req;
    logic         tap_wr;
    logic [W-1:0] tap_new;
    logic [W-1:0] tap_prog;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tap_drift_corrector #(.TAP_NUM(N)) i_tap_drift_corrector (
        .clk, .rst_n, .check_req, .timing_mode, .four_tap_en, .auto_en,
        .tune_busy, .req_flags, .cmd_sense, .tap_cur,
        .flag_clr, .retune_req, .tap_wr, .tap_new, .tap_prog
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int exp_tap = 0;
        int exp_prog = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "flag_clr", flag_clr, 0);
        chk("R1", "retune_req", retune_req, 0);
        chk("R1", "tap_wr", tap_wr, 0);
        chk("R1", "tap_new", tap_new, 0);
        chk("R1", "tap_prog", tap_prog, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "tap_wr after release", tap_wr, 0);

        for (int m = 0; m < 4; m++)
        for (int ft = 0; ft < 2; ft++)
        for (int au = 0; au < 2; au++)
        for (int bz = 0; bz < 2; bz++)
        for (int rq = 0; rq < 8; rq++)
        for (int cs = 0; cs < 4; cs++)
        for (int tp = 0; tp < N; tp++) begin
            bit act_ok, e_clr, e_ret, e_wr;
            int nt;
            string tag;
            e_clr = 0; e_ret = 0; e_wr = 0; nt = tp;
            act_ok = (m == 1 || m == 2 || (m == 3 && ft == 0)) && bz == 0;
            if (!(m == 1 || m == 2 || (m == 3 && ft == 0))) tag = "R2";
            else if (bz != 0) tag = "R3";
            else if (au != 0) tag = "R4";
            else if (rq == 0) tag = "R5";
            else if (m == 3) tag = "R7";
            else tag = "R6";
            if (act_ok) begin
                if (au != 0) begin
                    if (rq[2]) begin e_clr = 1; e_ret = 1; end
                end else if (rq != 0) begin
                    e_clr = 1;
                    if (m == 3) begin
                        if (cs == 2) begin e_wr = 1; nt = (tp + 1) % N; end
                        else if (cs == 1) begin e_wr = 1; nt = (tp + N - 1) % N; end
                        else if (cs == 3) e_ret = 1;
                    end else if (rq[2]) e_ret = 1;
                    else if (rq[1]) begin e_wr = 1; nt = (tp + 1) % N; end
                    else begin e_wr = 1; nt = (tp + N - 1) % N; end
                end
            end
            if (e_wr) begin
                exp_tap = nt;
                exp_prog = (ft != 0) ? nt / 2 : nt;
            end

            timing_mode = 2'(m);
            four_tap_en = 1'(ft);
            auto_en     = 1'(au);
            tune_busy   = 1'(bz);
            req_flags   = 3'(rq);
            cmd_sense   = 2'(cs);
            tap_cur     = W'(tp);
            check_req   = 1'b1;
            @(negedge clk);
            check_req = 1'b0;
            chk(tag, "flag_clr", flag_clr, int'(e_clr));
            chk(tag, "retune_req", retune_req, int'(e_ret));
            chk(tag, "tap_wr", tap_wr, int'(e_wr));
            chk("R8", "tap_new", tap_new, exp_tap);
            chk("R9", "tap_prog", tap_prog, exp_prog);
            @(negedge clk);
            // R10: single-cycle pulses, tap held without a write
            chk("R10", "pulse end", {flag_clr, retune_req, tap_wr}, 0);
            chk("R10", "tap hold", tap_new, exp_tap);
        end
        finish_run();
    end
endmodule